// File: doc/BRIEF.md
# Text-Mode Glyph Cell Pixel Serializer

This block sits between a text-mode address generator and a colour palette. It produces one 9-pixel-wide screen cell from three bytes: a character code, the font row for the current scanline (8 bits, one per dot) and an attribute byte. For each enabled pixel clock it emits a 4-bit colour index. The eight font dots fill the first eight columns. The ninth column acts as a spacer, so a line of 80 cells is 720 pixels wide.

The ninth column normally shows the background colour. Line-drawing characters instead extend their last font dot into that column, so their horizontal strokes meet the next cell without a gap. The attribute byte selects a foreground colour from 16, a background colour from 8, and whether the character blinks. An external blink-phase input hides the foreground dots of blinking characters. The block raises `cellFirst` in the column where it samples the next three bytes, so the upstream fetch logic knows when to present them.

Top module: `cell_pixel_serializer`

## Requirements
- R1: While reset is held and right after it is released, `pixColor` is 0 and `cellFirst` is 1.
- R2: A cell spans exactly 9 enabled pixel clocks. `cellFirst` is 1 only before the first of them. `charCode`, `fontRow` and `attr` are sampled on that first enabled edge. The colour of column k (k = 0..8) appears on `pixColor` after the (k+1)-th enabled edge of the cell.
- R3: Columns 0 to 7 show `fontRow` bits 7 down to 0, in that order. A set bit shows the foreground index `attr[3:0]`. A clear bit shows the background index `{1'b0, attr[6:4]}`.
- R4: For a character code below 0xC0 or above 0xDF, column 8 shows the background index.
- R5: For a character code from 0xC0 to 0xDF inclusive, column 8 repeats font bit 0: foreground if the bit is set, background if it is clear.
- R6: When `attr[7]` is 1 and `blinkPhase` is 0, every column shows the background index. When `blinkPhase` is 1, or when `attr[7]` is 0, the columns follow R3 to R5.
- R7: While `pixEn` is 0, the column position and `pixColor` hold their values.
- R8: Changes on `charCode`, `fontRow` and `attr` after a cell's first edge have no effect on that cell's columns 1 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | Pixel clock enable; one pixel per enabled edge |
| charCode | input | 8 | Character code of the next cell |
| fontRow | input | 8 | Font dots of the next cell, bit 7 leftmost |
| attr | input | 8 | Foreground [3:0], background [6:4], blink [7] |
| blinkPhase | input | 1 | 0 hides the foreground of blinking characters |
| cellFirst | output | 1 | Next enabled edge samples a new cell |
| pixColor | output | 4 | Colour index of the current pixel |

## Verification
The assertions assume that `pixEn` is the only thing that advances the column position. They also assume that the three input bytes only need to be valid on the edge flagged by `cellFirst`, while `blinkPhase` is taken fresh on every pixel. The stimulus presents each cell's bytes in the half cycle before that edge. It then drives the bitwise complement of those bytes for the rest of the cell, which tests that they are ignored. It keeps `blinkPhase` constant within a cell and holds `pixEn` low only in the middle of a cell.

// File: rtl/cellser_pkg.sv
package cellser_pkg;
  parameter int GLYPH_W = 8;
  parameter int CELL_W  = GLYPH_W + 1;
  parameter int FG_W    = 4;
  parameter int BG_W    = 3;
  parameter int ATTR_W  = FG_W + BG_W + 1;
  parameter int CODE_W  = 8;
  parameter int COL_W   = $clog2(CELL_W);
  parameter int BIT_W   = $clog2(GLYPH_W);

  typedef struct packed {
    logic             adv;
    logic             load;
    logic             ninth;
    logic [BIT_W-1:0] bitSel;
  } strobeT;
endpackage

// File: rtl/cellser_ctrl.sv
module cellser_ctrl
  import cellser_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pixEn,
  output strobeT strb,
  output logic   cellFirst
);
  localparam logic [COL_W-1:0] LAST = COL_W'(CELL_W - 1);

  logic [COL_W-1:0] col;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      col <= '0;
    else if (pixEn) col <= (col == LAST) ? '0 : col + 1'b1;
  end

  always_comb begin
    strb.adv    = pixEn;
    strb.load   = pixEn && (col == '0);
    strb.ninth  = pixEn && (col == LAST);
    strb.bitSel = col[BIT_W-1:0];
    cellFirst   = (col == '0);
  end

  // R2: column position never leaves the cell
  a_r2_col_range: assert property (@(posedge clk) disable iff (!rstN)
    col <= LAST);
  // R2: the last column wraps to the first
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && col == LAST) |=> (col == '0));
  // R7: no advance without enable
  a_r7_col_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(col));
endmodule

// File: rtl/cellser_dpath.sv
module cellser_dpath
  import cellser_pkg::*;
#(
  parameter logic [CODE_W-1:0] LINE_LO = 8'hC0,
  parameter logic [CODE_W-1:0] LINE_HI = 8'hDF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [CODE_W-1:0] charCode,
  input  logic [GLYPH_W-1:0] fontRow,
  input  logic [ATTR_W-1:0] attr,
  input  logic              blinkPhase,
  output logic [FG_W-1:0]   pixColor
);
  logic [GLYPH_W-1:0] fontQ;
  logic [CODE_W-1:0]  codeQ;
  logic [ATTR_W-1:0]  attrQ;

  logic [GLYPH_W-1:0] curFont;
  logic [CODE_W-1:0]  curCode;
  logic [ATTR_W-1:0]  curAttr;
  logic               lineCode, dot, blinkMask;
  logic [FG_W-1:0]    fgIdx, bgIdx, nextPix;

  always_comb begin
    curFont   = strb.load ? fontRow  : fontQ;
    curCode   = strb.load ? charCode : codeQ;
    curAttr   = strb.load ? attr     : attrQ;
    lineCode  = (curCode >= LINE_LO) && (curCode <= LINE_HI);
    dot       = strb.ninth ? (lineCode & curFont[0])
                           : curFont[BIT_W'(GLYPH_W - 1) - strb.bitSel];
    blinkMask = curAttr[ATTR_W-1] & ~blinkPhase;
    fgIdx     = curAttr[FG_W-1:0];
    bgIdx     = {{(FG_W-BG_W){1'b0}}, curAttr[FG_W+BG_W-1:FG_W]};
    nextPix   = (dot & ~blinkMask) ? fgIdx : bgIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fontQ    <= '0;
      codeQ    <= '0;
      attrQ    <= '0;
      pixColor <= '0;
    end else begin
      if (strb.load) begin
        fontQ <= fontRow;
        codeQ <= charCode;
        attrQ <= attr;
      end
      if (strb.adv) pixColor <= nextPix;
    end
  end

  // R7: colour holds while stalled
  a_r7_pix_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv |=> $stable(pixColor));
  // R4: spacer column of ordinary codes is background
  a_r4_ninth_blank: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ninth && !((codeQ >= LINE_LO) && (codeQ <= LINE_HI)))
      |=> (pixColor == {{(FG_W-BG_W){1'b0}}, $past(attrQ[FG_W+BG_W-1:FG_W])}));
  // R8: latched cell bytes change only on a load strobe
  a_r8_latch_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(fontQ) && $stable(attrQ) && $stable(codeQ)));
  // R6: a hidden blinking character shows no foreground index above 7
  a_r6_blink_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.load && attrQ[ATTR_W-1] && !blinkPhase)
      |=> (pixColor[FG_W-1] == 1'b0));
endmodule

// File: rtl/cell_pixel_serializer.sv
module cell_pixel_serializer
  import cellser_pkg::*;
#(
  parameter logic [CODE_W-1:0] LINE_LO = 8'hC0,
  parameter logic [CODE_W-1:0] LINE_HI = 8'hDF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic [CODE_W-1:0]  charCode,
  input  logic [GLYPH_W-1:0] fontRow,
  input  logic [ATTR_W-1:0]  attr,
  input  logic               blinkPhase,
  output logic               cellFirst,
  output logic [FG_W-1:0]    pixColor
);
  strobeT strb;

  cellser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .strb(strb), .cellFirst(cellFirst)
  );

  cellser_dpath #(.LINE_LO(LINE_LO), .LINE_HI(LINE_HI)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .charCode(charCode),
    .fontRow(fontRow), .attr(attr), .blinkPhase(blinkPhase),
    .pixColor(pixColor)
  );
endmodule

// File: tb/sim_cell_pixel_serializer.sv
module sim_cell_pixel_serializer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixEn = 1'b0;
  logic [7:0] charCode = '0, fontRow = '0, attr = '0;
  logic       blinkPhase = 1'b1;
  logic       cellFirst;
  logic [3:0] pixColor;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cell_pixel_serializer u0 (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .charCode(charCode),
    .fontRow(fontRow), .attr(attr), .blinkPhase(blinkPhase),
    .cellFirst(cellFirst), .pixColor(pixColor)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expPix(input logic [7:0] c, f, a, input logic b, input int k);
    logic on;
    if (k < 8) on = f[7-k];
    else       on = (c >= 8'hC0 && c <= 8'hDF) ? f[0] : 1'b0;
    if (a[7] && !b) on = 1'b0;
    return on ? a[3:0] : {1'b0, a[6:4]};
  endfunction

  // Starts at a falling edge with cellFirst high; ends in the same state.
  task automatic runCell(input logic [7:0] c, f, a, input logic b,
                         input int stallAt, input string tag);
    logic [3:0] exp;
    string req;
    check(cellFirst === 1'b1, "R2", cellFirst, 1);
    charCode = c; fontRow = f; attr = a; blinkPhase = b; pixEn = 1'b1;
    for (int k = 0; k < 9; k++) begin
      @(posedge clk); @(negedge clk);
      exp = expPix(c, f, a, b, k);
      if (k == 8) req = (c >= 8'hC0 && c <= 8'hDF) ? "R5" : "R4";
      else        req = tag;
      if (a[7] && !b) req = "R6";
      check(pixColor === exp, req, pixColor, exp);
      if (k > 0 && k < 8) check(cellFirst === 1'b0, "R2", cellFirst, 0);
      if (k == 0) begin charCode = ~c; fontRow = ~f; attr = ~a; end // R8
      if (k == stallAt) begin
        pixEn = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(posedge clk); @(negedge clk);
          check(pixColor === exp, "R7", pixColor, exp);
          check(cellFirst === 1'b0, "R7", cellFirst, 0);
        end
        pixEn = 1'b1;
      end
    end
    check(cellFirst === 1'b1, "R2", cellFirst, 1);
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    check(pixColor === 4'd0, "R1", pixColor, 0);
    check(cellFirst === 1'b1, "R1", cellFirst, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(pixColor === 4'd0, "R1", pixColor, 0);
    check(cellFirst === 1'b1, "R1", cellFirst, 1);
  endtask

  task automatic tPlain;
    runCell(8'h41, 8'b1010_0110, 8'h2E, 1'b1, -1, "R3/R8");
    runCell(8'h00, 8'hFF,        8'h79, 1'b1, -1, "R3/R8");
    runCell(8'hE5, 8'h01,        8'h53, 1'b0, -1, "R3/R8");
    runCell(8'hFF, 8'h81,        8'h0F, 1'b1, -1, "R3/R8");
  endtask

  task automatic tLineCodes;
    runCell(8'hBF, 8'h81, 8'h1A, 1'b1, -1, "R3");
    runCell(8'hC0, 8'h81, 8'h1A, 1'b1, -1, "R5");
    runCell(8'hDF, 8'h3F, 8'h6C, 1'b1, -1, "R5");
    runCell(8'hE0, 8'h81, 8'h1A, 1'b1, -1, "R3");
    runCell(8'hC5, 8'hF0, 8'h42, 1'b1, -1, "R5");
  endtask

  task automatic tBlink;
    runCell(8'hC4, 8'hFF, 8'h9E, 1'b0, -1, "R6");
    runCell(8'hC4, 8'hFF, 8'h9E, 1'b1, -1, "R6");
    runCell(8'h33, 8'hA5, 8'h1E, 1'b0, -1, "R6");
  endtask

  task automatic tStall;
    runCell(8'h52, 8'b1100_1010, 8'h3B, 1'b1, 3, "R7");
    runCell(8'hD0, 8'h0F,        8'h47, 1'b1, 6, "R7");
  endtask

  initial begin
    tReset;
    tPlain;
    tLineCodes;
    tBlink;
    tStall;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule